// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block moves a run of 32-bit words from one place in memory to another without help from the processor. Software writes a command into a small register file: a source byte address, a sink byte address, an item count and a step mode for each of the two addresses. Software then writes a start bit. The engine reads one word from the source and writes it to the sink, then moves on to the next item. Before each new item it adjusts each address by its own mode.

Each address can count up, count down or stay fixed, and the two choices are independent. A fixed sink gives a word stream into a device register. A fixed source gives a block fill, or a drain of a device register into memory. Every memory request waits on a ready handshake. When the last item is written, or at once when the count is zero, the engine raises a single interrupt. The interrupt stays high until software clears it.

Top module: `dma_engine`

## Requirements
- R1: After reset, every command register and the status word read as zero, `irq` and `busy` are low and no memory request is made. Registers are reached through `cfg_addr`: 0 source address, 1 sink address, 2 item count, 3 mode, 4 control on write and status on read. Status bit 0 is busy and bit 1 is the pending interrupt.
- R2: Writing control bit 0 while idle starts a transfer. `busy` reads high from the next cycle until the transfer has finished. No memory request is made while idle.
- R3: Each item is one read request (`mem_we` low) at the source address, followed by one write request (`mem_we` high) at the sink address. The write carries the word returned by that read.
- R4: Mode bits [1:0] set the source step: 1 adds 4 after each item, 2 subtracts 4, and 0 or 3 keeps the address fixed.
- R5: Mode bits [3:2] set the sink step with the same encoding, independently of the source step.
- R6: A transfer performs exactly as many write beats as the item count. A count of zero makes no memory request and still completes with the interrupt.
- R7: `irq` rises once, when the transfer completes. It stays high until control bit 1 is written, and a clear then drops it in the next cycle.
- R8: While busy, a write of the start bit is ignored, and writes to registers 0 to 3 leave their stored values unchanged.
- R9: A request whose `mem_ready` is low holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | High for a write beat, low for a read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read |
| mem_ready | input | 1 | Accepts the current request |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt, held until cleared |

## Verification
The bench runs every pairing of the increment, decrement and hold modes on the source and on the sink, each with item counts of zero, one, two and five. It checks the whole memory against a copy computed from those rules. A swapped or wrong step direction moves data to the wrong words. A fixed address shows up as a fill, or as only the last word surviving at the sink, and a count error leaves words missing or extra. Every run stalls the ready line on a repeating pattern, so a request that drifts during a stall corrupts the copy. A separate run writes the start bit and a new source address in the middle of a transfer, which tells a locked command apart from one that can be overwritten.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef logic [31:0] addr_t;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_RSVD = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2,
    SEQ_FIN   = 2'd3
  } seq_e;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_MODE = 3'd3;
  localparam logic [2:0] REG_CTRL = 3'd4;

  // Reserved code 3 behaves as a fixed address.
  function automatic step_e decode_step(input logic [1:0] field);
    step_e s;
    case (field)
      2'd1:    s = STEP_UP;
      2'd2:    s = STEP_DOWN;
      default: s = STEP_HOLD;
    endcase
    return s;
  endfunction

  function automatic addr_t next_addr(input addr_t cur, input step_e mode, input addr_t stride);
    addr_t n;
    case (mode)
      STEP_UP:   n = cur + stride;
      STEP_DOWN: n = cur - stride;
      default:   n = cur;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          busy,
  input  logic          done_evt,
  output addr_t         src_q,
  output addr_t         dst_q,
  output logic [CW-1:0] cnt_q,
  output step_e         src_mode,
  output step_e         dst_mode,
  output logic          irq,
  output logic          start_evt,
  output logic          clear_evt
);
  logic [3:0] mode_q;
  logic       cmd_wr;

  assign cmd_wr    = cfg_we && !busy;
  assign start_evt = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[0];
  assign clear_evt = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[1];
  assign src_mode  = decode_step(mode_q[1:0]);
  assign dst_mode  = decode_step(mode_q[3:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
    end else if (cmd_wr) begin
      case (cfg_addr)
        REG_SRC:  src_q  <= cfg_wdata;
        REG_DST:  dst_q  <= cfg_wdata;
        REG_CNT:  cnt_q  <= cfg_wdata[CW-1:0];
        REG_MODE: mode_q <= cfg_wdata[3:0];
        default:  ;
      endcase
    end
  end

  // Completion wins over a clear arriving in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)         irq <= 1'b0;
    else if (done_evt)  irq <= 1'b1;
    else if (clear_evt) irq <= 1'b0;
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_SRC:  cfg_rdata = src_q;
      REG_DST:  cfg_rdata = dst_q;
      REG_CNT:  cfg_rdata[CW-1:0] = cnt_q;
      REG_MODE: cfg_rdata[3:0] = mode_q;
      REG_CTRL: cfg_rdata[1:0] = {irq, busy};
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_ptr.sv
module dma_ptr
  import dma_pkg::*;
#(
  parameter int STRIDE = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t base,
  input  logic  advance,
  input  step_e mode,
  output addr_t ptr
);
  localparam addr_t STRIDE_A = addr_t'(STRIDE);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (load)    ptr <= base;
    else if (advance) ptr <= next_addr(ptr, mode, STRIDE_A);
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] count,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic          rd_beat,
  output logic          wr_beat,
  output logic          done_evt,
  output logic [DW-1:0] data_q
);
  seq_e          state;
  logic [CW-1:0] remaining;
  logic          last_item;

  assign busy      = (state != SEQ_IDLE);
  assign mem_req   = (state == SEQ_READ) || (state == SEQ_WRITE);
  assign mem_we    = (state == SEQ_WRITE);
  assign rd_beat   = (state == SEQ_READ) && mem_ready;
  assign wr_beat   = (state == SEQ_WRITE) && mem_ready;
  assign done_evt  = (state == SEQ_FIN);
  assign last_item = (remaining == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      remaining <= '0;
      data_q    <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (go) begin
          remaining <= count;
          state     <= (count == '0) ? SEQ_FIN : SEQ_READ;
        end
        SEQ_READ: if (rd_beat) begin
          data_q <= mem_rdata;
          state  <= SEQ_WRITE;
        end
        SEQ_WRITE: if (wr_beat) begin
          remaining <= remaining - CW'(1);
          state     <= last_item ? SEQ_FIN : SEQ_READ;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          irq
);
  localparam int STRIDE = DW / 8;

  addr_t         src_q, dst_q, src_ptr, dst_ptr;
  logic [CW-1:0] cnt_q;
  step_e         src_mode, dst_mode;
  logic          start_evt, clear_evt, go;
  logic          rd_beat, wr_beat, done_evt;
  logic [DW-1:0] data_q;

  assign go = start_evt && !busy;

  dma_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .done_evt(done_evt), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
    .src_mode(src_mode), .dst_mode(dst_mode), .irq(irq),
    .start_evt(start_evt), .clear_evt(clear_evt)
  );

  dma_seq #(.CW(CW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .count(cnt_q),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .rd_beat(rd_beat),
    .wr_beat(wr_beat), .done_evt(done_evt), .data_q(data_q)
  );

  dma_ptr #(.STRIDE(STRIDE)) u_src_ptr (
    .clk(clk), .rst_n(rst_n), .load(go), .base(src_q),
    .advance(rd_beat), .mode(src_mode), .ptr(src_ptr)
  );

  dma_ptr #(.STRIDE(STRIDE)) u_dst_ptr (
    .clk(clk), .rst_n(rst_n), .load(go), .base(dst_q),
    .advance(wr_beat), .mode(dst_mode), .ptr(dst_ptr)
  );

  assign mem_addr  = mem_we ? dst_ptr : src_ptr;
  assign mem_wdata = data_q;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk
  import dma_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [31:0]   mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          irq,
  input logic          rd_beat,
  input logic          wr_beat,
  input logic          done_evt,
  input logic          clear_evt,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input addr_t         src_q,
  input addr_t         src_ptr,
  input addr_t         dst_ptr,
  input step_e         src_mode,
  input step_e         dst_mode
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |=> mem_req && mem_we);

  assert_src_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat && src_mode == STEP_UP |=> src_ptr == $past(src_ptr) + 32'd4);

  assert_dst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat && dst_mode == STEP_HOLD |=> $stable(dst_ptr));

  assert_irq_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq && !busy);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clear_evt |=> irq);

  assert_cmd_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_we && cfg_addr == REG_SRC |=> $stable(src_q));
endmodule

bind dma_engine dma_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .irq(irq), .rd_beat(rd_beat), .wr_beat(wr_beat),
  .done_evt(done_evt), .clear_evt(clear_evt), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .src_q(src_q), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
  .src_mode(src_mode), .dst_mode(dst_mode)
);

// File: tb/sim_dma_engine.sv
`timescale 1ns/1ps
module sim_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we, busy, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int wr_seen;
  int req_idle;
  logic init_req = 1'b0;
  logic [2:0] rdy_cnt = '0;

  logic [31:0] mem [64];
  logic [31:0] exp_mem [64];

  always #5 clk = ~clk;

  dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .irq(irq)
  );

  assign mem_rdata = mem[mem_addr[7:2]];

  function automatic logic [31:0] seed_word(input int i);
    return 32'hC0DE_0000 + 32'(i * 7 + 3);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (init_req) begin
      for (int i = 0; i < 64; i++) mem[i] <= seed_word(i);
      wr_seen  <= 0;
      req_idle <= 0;
    end else begin
      if (mem_req && mem_we && mem_ready) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wr_seen <= wr_seen + 1;
      end
      if (mem_req && !busy) req_idle <= req_idle + 1;
    end
  end

  // Ready stalls on one of every eight cycles, plus a second hole.
  always @(negedge clk) begin
    rdy_cnt   <= rdy_cnt + 3'd1;
    mem_ready <= !(rdy_cnt == 3'd2 || rdy_cnt == 3'd5);
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic reseed();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    for (int i = 0; i < 64; i++) exp_mem[i] = seed_word(i);
  endtask

  function automatic int word_at(input int base, input int mode, input int k);
    if (mode == 1) return base + k;
    if (mode == 2) return base - k;
    return base;
  endfunction

  task automatic wait_irq();
    int t = 0;
    while (irq !== 1'b1 && t < 2000) begin
      @(negedge clk); t++;
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 64; i++)
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) check(req, 32'd0, 32'd0);
    else check(req, mem[first], exp_mem[first]);
  endtask

  task automatic run_copy(input int sm, input int dm, input int n);
    logic [31:0] v;
    int sb = 10;
    int db = 40;
    reseed();
    for (int k = 0; k < n; k++)
      exp_mem[word_at(db, dm, k)] = exp_mem[word_at(sb, sm, k)];
    wr_reg(3'd0, 32'(sb * 4));
    wr_reg(3'd1, 32'(db * 4));
    wr_reg(3'd2, 32'(n));
    wr_reg(3'd3, 32'((dm << 2) | sm));
    wr_reg(3'd4, 32'h1);
    check($sformatf("R2 busy after start sm=%0d dm=%0d n=%0d", sm, dm, n), {31'd0, busy}, 32'd1);
    wait_irq();
    check($sformatf("R7 irq at completion n=%0d", n), {31'd0, irq}, 32'd1);
    check("R2 busy low after completion", {31'd0, busy}, 32'd0);
    repeat (3) @(negedge clk);
    check("R7 irq held until cleared", {31'd0, irq}, 32'd1);
    compare_mem($sformatf("R3 R4 R5 R9 memory sm=%0d dm=%0d n=%0d", sm, dm, n));
    check($sformatf("R6 write beats n=%0d", n), 32'(wr_seen), 32'(n));
    rd_reg(3'd4, v);
    check("R1 status shows pending irq", v, 32'h2);
    wr_reg(3'd4, 32'h2);
    check("R7 irq cleared", {31'd0, irq}, 32'd0);
    check("R2 no request while idle", 32'(req_idle), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 busy after reset", {31'd0, busy}, 32'd0);
    check("R1 no request after reset", {31'd0, mem_req}, 32'd0);
    for (int r = 0; r < 5; r++) begin
      rd_reg(3'(r), v);
      check($sformatf("R1 register %0d reset value", r), v, 32'd0);
    end

    // Full sweep of both step modes and several counts; mode 3 acts as hold.
    for (int sm = 0; sm < 3; sm++)
      for (int dm = 0; dm < 3; dm++)
        for (int ci = 0; ci < 4; ci++)
          run_copy(sm, dm, (ci == 3) ? 5 : ci);
    run_copy(3, 1, 3);
    run_copy(1, 3, 3);

    // R8: start and a new source written in the middle of a transfer.
    reseed();
    for (int k = 0; k < 4; k++) exp_mem[20 + k] = exp_mem[4 + k];
    wr_reg(3'd0, 32'd16);
    wr_reg(3'd1, 32'd80);
    wr_reg(3'd2, 32'd4);
    wr_reg(3'd3, 32'h5);
    wr_reg(3'd4, 32'h1);
    wr_reg(3'd0, 32'd200);
    wr_reg(3'd4, 32'h1);
    wait_irq();
    repeat (20) @(negedge clk);
    compare_mem("R8 memory with start while busy");
    check("R8 single transfer write beats", 32'(wr_seen), 32'd4);
    check("R8 busy stays low after restart attempt", {31'd0, busy}, 32'd0);
    rd_reg(3'd0, v);
    check("R8 source register locked while busy", v, 32'd16);
    wr_reg(3'd4, 32'h2);
    check("R7 clear after locked run", {31'd0, irq}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule